// File: doc/BRIEF.md
# Serial Input Clock Pulse Skipper

This block sits on one channel's serial bit path, between the sigma-delta bit input and that channel's decimation filter. Software writes a skip count of 1 to 63. The block then discards that many input beats, one beat for each input clock pulse. The dropped bits never reach the filter, and the later bits take their place. Every filter output produced after the skip is therefore computed from newer input samples. This shifts the channel's sampling phase against the other channels.

The bit path is a valid/ready stream with a single output register. While skips remain, the block accepts every offered beat and throws it away, so an upstream source is never stalled by a skip. When no skips remain, a beat is accepted only if the output register is empty or is being drained in the same cycle. The output holds its valid flag and data steady while `bit_out_ready` is low. The remaining count can be read at any time on `skip_left`, and zero means the skip is finished. Skips larger than 63 need several writes, and the block keeps no running total across writes.

Top module: `pulse_skipper`

## Requirements
- R1: On a cycle with `rst` high, `skip_left` is 0 and `bit_out_valid` is 0 on the following cycle.
- R2: A write (`skip_wr` high) loads `skip_wr_count` into `skip_left` at that clock edge. The beat accepted in the same cycle as the write is judged against the count held before the write.
- R3: Each accepted beat while `skip_left` is nonzero lowers `skip_left` by exactly one and produces no output beat.
- R4: While `skip_left` is 0, each accepted beat appears on `bit_out_data` with `bit_out_valid` high one cycle after acceptance, and beats keep their order.
- R5: Writing 0 while skips remain cancels the rest, so the beats that follow pass through.
- R6: Writing a nonzero value while skips remain replaces the remaining count rather than adding to it.
- R7: While `bit_out_valid` is high and `bit_out_ready` is low, the output beat and its data stay unchanged. In that state, with `skip_left` at 0, `bit_in_ready` is low.
- R8: While `skip_left` is nonzero, `bit_in_ready` is high whatever the state of the output.
- R9: The largest count, 63, skips exactly 63 beats and then `skip_left` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| skip_wr | input | 1 | Write strobe for the skip count |
| skip_wr_count | input | 6 | Number of beats to skip; 0 cancels |
| skip_left | output | 6 | Skips still to be performed; 0 when finished |
| bit_in_valid | input | 1 | Input beat present (one input clock pulse) |
| bit_in_ready | output | 1 | Block accepts the input beat this cycle |
| bit_in_data | input | 1 | Serial data bit of the input beat |
| bit_out_valid | output | 1 | Output beat present toward the filter |
| bit_out_ready | input | 1 | Filter accepts the output beat |
| bit_out_data | output | 1 | Data bit toward the filter |

## Verification
The stream is first driven with the count at zero, with the output always ready. This shows that data passes unchanged with one cycle of latency. Small counts, the maximum count of 63, a cancelling write and a replacing write are then applied mid-skip. Together these separate a correct decrement from a count that adds up across writes, ignores a cancel, or lets a dropped bit leak through. One count is loaded while the output register is full and stalled, which shows that skipped beats are still accepted. A final run with a pseudo-random ready pattern shows that stalls neither lose, duplicate nor corrupt beats.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned SKIP_CNT_W = 6;
  localparam int unsigned SKIP_DATA_W = 1;

  function automatic logic [SKIP_CNT_W-1:0] count_step(input logic [SKIP_CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction
endpackage

// File: rtl/skip_count.sv
module skip_count
  import skip_pkg::*;
#(
  parameter int unsigned CNT_W = SKIP_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             beat_fire,
  output logic [CNT_W-1:0] remaining,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= wr_val;
    end else if (beat_fire) begin
      cnt_q <= count_step(cnt_q);
    end
  end

  assign remaining = cnt_q;
  assign busy      = (cnt_q != '0);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> remaining == $past(wr_val)); // R2

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && beat_fire && busy) |=> remaining == $past(remaining) - 1'b1); // R3

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !busy) |=> remaining == '0); // R3
endmodule

// File: rtl/beat_reg.sv
module beat_reg
  import skip_pkg::*;
#(
  parameter int unsigned DATA_W = SKIP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drain_ready,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              has_room
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
    end else if (drain_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dat_q <= load_data;
    end
  end

  assign hold_valid = vld_q;
  assign hold_data  = dat_q;
  assign has_room   = !vld_q || drain_ready;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !drain_ready) |=> hold_valid && $stable(hold_data)); // R7
endmodule

// File: rtl/pulse_skipper.sv
module pulse_skipper
  import skip_pkg::*;
#(
  parameter int unsigned CNT_W  = SKIP_CNT_W,
  parameter int unsigned DATA_W = SKIP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              skip_wr,
  input  logic [CNT_W-1:0]  skip_wr_count,
  output logic [CNT_W-1:0]  skip_left,
  input  logic              bit_in_valid,
  output logic              bit_in_ready,
  input  logic [DATA_W-1:0] bit_in_data,
  output logic              bit_out_valid,
  input  logic              bit_out_ready,
  output logic [DATA_W-1:0] bit_out_data
);
  logic skipping;
  logic room;
  logic fire;
  logic pass_load;

  assign bit_in_ready = skipping || room;
  assign fire         = bit_in_valid && bit_in_ready;
  assign pass_load    = fire && !skipping;

  skip_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (skip_wr),
    .wr_val    (skip_wr_count),
    .beat_fire (fire),
    .remaining (skip_left),
    .busy      (skipping)
  );

  beat_reg #(.DATA_W(DATA_W)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .load        (pass_load),
    .load_data   (bit_in_data),
    .drain_ready (bit_out_ready),
    .hold_valid  (bit_out_valid),
    .hold_data   (bit_out_data),
    .has_room    (room)
  );

  AST_DROP_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (bit_in_valid && bit_in_ready && skip_left != '0 && bit_out_ready) |=> !bit_out_valid); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (bit_in_valid && bit_in_ready && skip_left == '0)
      |=> bit_out_valid && bit_out_data == $past(bit_in_data)); // R4
endmodule

// File: tb/sim_pulse_skipper.sv
module sim_pulse_skipper;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       skip_wr = 1'b0;
  logic [5:0] skip_wr_count = '0;
  logic [5:0] skip_left;
  logic       bit_in_valid = 1'b0;
  logic       bit_in_ready;
  logic [0:0] bit_in_data = '0;
  logic       bit_out_valid;
  logic       bit_out_ready = 1'b0;
  logic [0:0] bit_out_data;

  int   n_checks = 0;
  int   n_fail = 0;
  logic exp_q[$];
  int   model_cnt = 0;
  logic ready_set = 1'b0;
  logic rand_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pulse_skipper u0 (
    .clk(clk), .rst(rst), .skip_wr(skip_wr), .skip_wr_count(skip_wr_count),
    .skip_left(skip_left), .bit_in_valid(bit_in_valid), .bit_in_ready(bit_in_ready),
    .bit_in_data(bit_in_data), .bit_out_valid(bit_out_valid),
    .bit_out_ready(bit_out_ready), .bit_out_data(bit_out_data)
  );

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ready source: directed level or pseudo-random pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bit_out_ready <= rand_mode ? lfsr[0] : ready_set;
  end

  // monitor: pops expected bits as the design delivers them
  logic held = 1'b0;
  logic held_bit = 1'b0;
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (mon_on) begin
      if (held) begin
        check("R7 held valid", int'(bit_out_valid), 1);
        check("R7 held data", int'(bit_out_data[0]), int'(held_bit));
      end
      held = 1'b0;
      if (bit_out_valid && bit_out_ready) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected output beat", 1, 0);
        end else begin
          check("R4 output data order", int'(bit_out_data[0]), int'(exp_q.pop_front()));
        end
      end else if (bit_out_valid) begin
        held = 1'b1;
        held_bit = bit_out_data[0];
      end
    end
  end

  // driver: offers one beat until accepted, optional write in the same cycle
  task automatic send(input logic b, input logic w_en = 1'b0, input logic [5:0] w_val = '0);
    logic ok;
    @(negedge clk);
    bit_in_valid = 1'b1;
    bit_in_data = b;
    skip_wr = w_en;
    skip_wr_count = w_val;
    forever begin
      #(CLK_P/4);
      ok = bit_in_ready;
      if (model_cnt != 0) check("R8 ready while skipping", int'(bit_in_ready), 1);
      if (ok) begin
        if (model_cnt != 0) model_cnt--;
        else exp_q.push_back(b);
        if (w_en) model_cnt = int'(w_val);
      end
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #1;
    bit_in_valid = 1'b0;
    skip_wr = 1'b0;
  endtask

  task automatic write_cnt(input logic [5:0] v);
    @(negedge clk);
    skip_wr = 1'b1;
    skip_wr_count = v;
    @(posedge clk);
    #1;
    skip_wr = 1'b0;
    model_cnt = int'(v);
  endtask

  task automatic check_left(input string req);
    @(negedge clk);
    #1;
    check(req, int'(skip_left), model_cnt);
  endtask

  task automatic drain();
    ready_set = 1'b1;
    rand_mode = 1'b0;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    check("R4 all beats delivered", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset skip_left", int'(skip_left), 0);
    check("R1 reset out_valid", int'(bit_out_valid), 0);
    mon_on = 1'b1;

    // pass-through, latency
    ready_set = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b1);
    @(negedge clk);
    #(CLK_P/4 - 1);
    check("R4 one-cycle latency valid", int'(bit_out_valid), 1);
    check("R4 one-cycle latency data", int'(bit_out_data[0]), 1);
    for (int i = 0; i < 7; i++) send(1'(i % 3 == 0));
    drain();

    // basic skip of 5
    write_cnt(6'd5);
    check_left("R2 loaded count");
    for (int i = 0; i < 12; i++) begin
      send(1'(i[0] ^ i[2]));
      if (i < 6) check_left("R3 decrement per beat");
    end
    drain();

    // skips accepted while output is full and stalled
    ready_set = 1'b0;
    repeat (2) @(negedge clk);
    send(1'b1);
    @(negedge clk);
    #(CLK_P/4);
    check("R7 input stalled when full", int'(bit_in_ready), 0);
    write_cnt(6'd3);
    for (int i = 0; i < 3; i++) send(1'b0);
    check_left("R8 skips done while stalled");
    drain();

    // maximum count
    write_cnt(6'd63);
    check_left("R9 max count loaded");
    for (int i = 0; i < 63; i++) send(1'b1);
    check_left("R9 max count finished");
    send(1'b0);
    send(1'b1);
    drain();

    // cancel
    write_cnt(6'd10);
    for (int i = 0; i < 4; i++) send(1'b1);
    write_cnt(6'd0);
    check_left("R5 cancel clears count");
    send(1'b0);
    send(1'b1);
    drain();

    // replace, no accumulation
    write_cnt(6'd10);
    for (int i = 0; i < 3; i++) send(1'b0);
    write_cnt(6'd2);
    check_left("R6 replaced not added");
    for (int i = 0; i < 4; i++) send(1'(i));
    check_left("R6 finished after replace");
    drain();

    // write in the same cycle as a beat
    send(1'b1, 1'b1, 6'd4);
    check_left("R2 same-cycle write loads");
    for (int i = 0; i < 6; i++) send(1'(i > 3));
    drain();

    // random back-pressure
    rand_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i == 10) write_cnt(6'd7);
      send(1'(i[0] ^ i[1] ^ i[3]));
    end
    check_left("R3 random phase done");
    drain();

    mon_on = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule